// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block answers a host that drives a small serial EEPROM by toggling register bits instead of using a real serial clock. The storage is 64 words of 16 bits. The host talks to it over a plain synchronous register bus with a write strobe, a read strobe, a one-bit register select and eight data bits. One register is a control/direction register. The other is a data register. Each accepted write to the data register counts as one serial clock step. Each read of the data register during a read transfer also counts as one step and returns one data bit.

A command is built one bit per step. First comes a start step, then two opcode bits, then six address bits, most significant first. After that the machine stays in a data phase. With the read opcode, successive data-register reads shift the addressed word out most significant bit first. The first read returns a dummy zero. With the write opcode, successive accepted data-register writes shift bits into the word. The first of those writes is also a dummy and stores nothing. After every 16 data bits the word address moves on by one, and it wraps from 63 to 0.

A side port loads whole words into the array so the surrounding test environment can set up known contents.

Top module: `ee_bitbang_responder`

## Requirements
- R1: A write to either register takes effect only when bits 7 and 6 of the written value are both 1. Any other write changes no state: no step, no opcode, address or counter change, and no direction change.
- R2: An accepted control-register write (select 0) latches written bits 5:4 as the direction field. A control-register read returns that field in bits 5:4, with all other bits zero. An accepted control write whose bits 5:4 are binary 10 puts the step machine back into its ready state.
- R3: Each accepted data-register write (select 1) advances the machine one step through: ready, opcode-high, opcode-low, six address steps, data. The machine then stays in data.
- R4: The ready step clears the opcode. The opcode-high step takes written bit 5 as opcode bit 1, and the opcode-low step takes it as opcode bit 0. Opcode 2 reads and opcode 1 writes. Opcodes 0 and 3 transfer nothing in the data phase: their reads return zero and their writes store nothing.
- R5: The six address steps take written bit 5 into word-address bits 5 down to 0, in that order.
- R6: The opcode-high step loads the bit counter with an all-ones marker. The first data-phase transfer after that is a dummy: a read returns a zero bit, a write stores nothing, and the counter then restarts at 0.
- R7: A data-register read in the data phase with the read opcode returns bit (15 − counter) of the current word on bit 4, with all other bits zero. The counter then increments.
- R8: After the 16th data bit of a word, in either direction, the bit counter returns to 0 and the word address increments, wrapping from 63 to 0.
- R9: An accepted data-register write in the data phase with the write opcode stores written bit 5 into bit (15 − counter) of the current word. Bits are therefore filled most significant first.
- R10: A data-register read outside the data phase, or with a non-read opcode, returns zero and changes no state.
- R11: Reset clears the step machine to ready, the opcode, address, bit counter and direction field to zero, and the read data to zero.
- R12: A side-port load writes a whole word at the given address. Those contents are later returned by read transfers.
- R13: Read data appears on the clock edge that samples the read strobe. It holds its value until the next read. Read and write strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 control/direction, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| load_en | input | 1 | Side-port whole-word load strobe |
| load_addr | input | 6 | Side-port word address |
| load_word | input | 16 | Side-port word value |

## Verification
Every strobe takes effect on the rising edge that samples it. Step, opcode, address and counter changes are visible to the next access, and `bus_rdata` carries the read result from that same edge onward. The bench raises a strobe just after a falling edge and drops it at the next falling edge. It samples `bus_rdata` at that falling edge, which is one full edge after the strobe was seen and half a period before anything else can change. Because write effects can only be seen through later reads, each stored word is checked by reading it back at least one full command later.

// File: rtl/ee_bb_pkg.sv
`timescale 1ns/1ps
package ee_bb_pkg;
  // opcode values carried through the two opcode steps
  typedef enum logic [1:0] {
    OPC_IDLE  = 2'd0,
    OPC_WRITE = 2'd1,
    OPC_READ  = 2'd2,
    OPC_RSVD  = 2'd3
  } opcode_e;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  // bit positions the host encodes into the 8-bit registers
  localparam int GATE_LO  = 6;  // bits GATE_LO+1:GATE_LO must be 11
  localparam int DIN_POS  = 5;  // serial data in
  localparam int DOUT_POS = 4;  // serial data out
  localparam int DIR_LO   = 4;  // direction field, two bits

  localparam logic [1:0] DIR_RESTART = 2'b10;

  // step indices; address steps follow ST_ADDR_FIRST, data follows them
  localparam int ST_READY      = 0;
  localparam int ST_OPC_HI     = 1;
  localparam int ST_OPC_LO     = 2;
  localparam int ST_ADDR_FIRST = 3;
endpackage

// File: rtl/ee_step_fsm.sv
`timescale 1ns/1ps
module ee_step_fsm
  import ee_bb_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 16,
  parameter int CNT_W   = $clog2(WORD_W) + 1,
  parameter int STATE_W = $clog2(ADDR_W + 4)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_wr,    // accepted data-register write
  input  logic               step_rd,    // data-register read
  input  logic               restart,    // control write requesting ready
  input  logic               din,
  output logic [STATE_W-1:0] state_o,
  output logic [1:0]         opcode_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               store_en,   // store din into current bit
  output logic               read_live   // read returns a real word bit
);
  localparam logic [STATE_W-1:0] S_READY = STATE_W'(ST_READY);
  localparam logic [STATE_W-1:0] S_OPHI  = STATE_W'(ST_OPC_HI);
  localparam logic [STATE_W-1:0] S_OPLO  = STATE_W'(ST_OPC_LO);
  localparam logic [STATE_W-1:0] S_ADDR0 = STATE_W'(ST_ADDR_FIRST);
  localparam logic [STATE_W-1:0] S_DATA  = STATE_W'(ST_ADDR_FIRST + ADDR_W);
  localparam logic [CNT_W-1:0]   CNT_MARK = '1;
  localparam logic [CNT_W-1:0]   CNT_LAST = CNT_W'(WORD_W - 1);

  logic [STATE_W-1:0] state_q;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   cnt_q;

  logic               in_data;
  logic               xfer_rd;
  logic               xfer_wr;
  logic               at_mark;
  logic [STATE_W-1:0] a_idx;
  logic [ADDR_W-1:0]  a_mask;

  assign in_data = (state_q == S_DATA);
  assign at_mark = (cnt_q == CNT_MARK);
  assign xfer_rd = step_rd && in_data && (op_q == OPC_READ);
  assign xfer_wr = step_wr && in_data && (op_q == OPC_WRITE);
  assign a_idx   = state_q - S_ADDR0;
  assign a_mask  = {1'b1, {(ADDR_W-1){1'b0}}} >> a_idx;

  assign store_en  = xfer_wr && !at_mark;
  assign read_live = xfer_rd && !at_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_READY;
      op_q    <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else if (restart) begin
      state_q <= S_READY;
    end else if (step_wr && !in_data) begin
      state_q <= state_q + 1'b1;
      if (state_q == S_READY) begin
        op_q <= '0;
      end else if (state_q == S_OPHI) begin
        op_q[1] <= din;
        cnt_q   <= CNT_MARK;
      end else if (state_q == S_OPLO) begin
        op_q[0] <= din;
      end else begin
        addr_q <= din ? (addr_q | a_mask) : (addr_q & ~a_mask);
      end
    end else if (xfer_rd || xfer_wr) begin
      if (at_mark) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o  = state_q;
  assign opcode_o = op_q;
  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/ee_word_store.sv
`timescale 1ns/1ps
module ee_word_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_word,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  bit_pos,
  input  logic              bit_in,
  output logic              bit_out
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  // whole-word load has priority over a single-bit serial store
  always_ff @(posedge clk) begin
    if (load_en) begin
      mem_q[load_addr] <= load_word;
    end else if (bit_we) begin
      mem_q[addr][bit_pos] <= bit_in;
    end
  end

  assign bit_out = mem_q[addr][bit_pos];
endmodule

// File: rtl/ee_bitbang_responder.sv
`timescale 1ns/1ps
module ee_bitbang_responder
  import ee_bb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_word
);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int CNT_W   = BIT_W + 1;
  localparam int STATE_W = $clog2(ADDR_W + 4);

  logic               gate_ok;
  logic               wr_ctrl;
  logic               wr_data;
  logic               rd_ctrl;
  logic               rd_data;
  logic               restart;
  logic               din;
  logic [1:0]         dir_q;
  logic [DATA_W-1:0]  rdata_q;

  logic [STATE_W-1:0] state_w;
  logic [1:0]         opcode_w;
  logic [ADDR_W-1:0]  addr_w;
  logic [CNT_W-1:0]   cnt_w;
  logic               store_en;
  logic               read_live;
  logic [BIT_W-1:0]   bit_pos;
  logic               word_bit;

  assign gate_ok = (bus_wdata[GATE_LO+1:GATE_LO] == 2'b11);
  assign wr_ctrl = bus_wr && (bus_sel == SEL_CTRL) && gate_ok;
  assign wr_data = bus_wr && (bus_sel == SEL_DATA) && gate_ok;
  assign rd_ctrl = bus_rd && !bus_wr && (bus_sel == SEL_CTRL);
  assign rd_data = bus_rd && !bus_wr && (bus_sel == SEL_DATA);
  assign restart = wr_ctrl && (bus_wdata[DIR_LO+1:DIR_LO] == DIR_RESTART);
  assign din     = bus_wdata[DIN_POS];

  ee_step_fsm #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W),
    .STATE_W(STATE_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .step_wr  (wr_data),
    .step_rd  (rd_data),
    .restart  (restart),
    .din      (din),
    .state_o  (state_w),
    .opcode_o (opcode_w),
    .addr_o   (addr_w),
    .cnt_o    (cnt_w),
    .store_en (store_en),
    .read_live(read_live)
  );

  // most significant bit first: counter 0 selects bit WORD_W-1
  assign bit_pos = BIT_W'(WORD_W - 1) - cnt_w[BIT_W-1:0];

  ee_word_store #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .BIT_W (BIT_W)
  ) u_store (
    .clk      (clk),
    .load_en  (load_en),
    .load_addr(load_addr),
    .load_word(load_word),
    .bit_we   (store_en),
    .addr     (addr_w),
    .bit_pos  (bit_pos),
    .bit_in   (din),
    .bit_out  (word_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (wr_ctrl) begin
      dir_q <= bus_wdata[DIR_LO+1:DIR_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_data) begin
      rdata_q           <= '0;
      rdata_q[DOUT_POS] <= read_live & word_bit;
    end else if (rd_ctrl) begin
      rdata_q                  <= '0;
      rdata_q[DIR_LO+1:DIR_LO] <= dir_q;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ee_bitbang_checker.sv
`timescale 1ns/1ps
module ee_bitbang_checker #(
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = $clog2(WORD_W) + 1,
  parameter int STATE_W = $clog2(ADDR_W + 4)
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               bus_sel,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [STATE_W-1:0] state,
  input logic [1:0]         opcode,
  input logic [ADDR_W-1:0]  addr,
  input logic [CNT_W-1:0]   cnt
);
  localparam logic [STATE_W-1:0] S_DATA   = STATE_W'(ADDR_W + 3);
  localparam logic [CNT_W-1:0]   CNT_MARK = '1;
  localparam logic [CNT_W-1:0]   CNT_LAST = CNT_W'(WORD_W - 1);

  logic top_ok;
  logic dread;
  logic live_rd;
  assign top_ok  = (bus_wdata[7:6] == 2'b11);
  assign dread   = bus_rd && !bus_wr && bus_sel;
  assign live_rd = dread && (state == S_DATA) && (opcode == 2'd2);

  assert_ignored_write_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !top_ok) |=> ($stable(state) && $stable(addr) && $stable(cnt) && $stable(opcode)));

  assert_dir_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_sel && bus_wdata[7:4] == 4'b1110) |=> (state == '0));

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && top_ok && state != S_DATA) |=> (state == STATE_W'($past(state) + 1'b1)));

  assert_marker_load_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && top_ok && state == STATE_W'(1)) |=> (cnt == CNT_MARK));

  assert_read_format_R7: assert property (@(posedge clk) disable iff (rst)
    dread |=> ((bus_rdata & ~DATA_W'(8'h10)) == '0));

  assert_word_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (live_rd && cnt == CNT_LAST) |=> (cnt == '0 && addr == ADDR_W'($past(addr) + 1'b1)));

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA) |-> (cnt <= CNT_LAST || cnt == CNT_MARK));

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (rst)
    (dread && !(state == S_DATA && opcode == 2'd2)) |=>
      (bus_rdata == '0 && $stable(cnt) && $stable(addr) && $stable(state)));
endmodule

bind ee_bitbang_responder ee_bitbang_checker #(
  .ADDR_W(ADDR_W),
  .WORD_W(WORD_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_sel  (bus_sel),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .state    (state_w),
  .opcode   (opcode_w),
  .addr     (addr_w),
  .cnt      (cnt_w)
);

// File: tb/tb_ee_bitbang_responder.sv
`timescale 1ns/1ps
module tb_ee_bitbang_responder;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic        bus_rd;
  logic        bus_sel;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        load_en;
  logic [5:0]  load_addr;
  logic [15:0] load_word;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [15:0] model [64];

  always #2.5 clk = ~clk;

  ee_bitbang_responder dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_en(load_en),
    .load_addr(load_addr), .load_word(load_word)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [7:0] r);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0;
    r = bus_rdata;
  endtask

  function automatic logic [7:0] junk();
    logic [7:0] v = 8'($urandom);
    if (v[7:6] == 2'b11) v[6] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] step(logic b);
    return 8'hC0 | (8'(b) << 5);
  endfunction

  task automatic noise(bit en);
    if (en && ($urandom % 4) == 0) begin
      if ($urandom % 2) wr(1'b1, junk());
      else wr(1'b0, junk() & 8'h3F | 8'h20);   // restart pattern but top bits not 11
    end
  endtask

  // restart, start step, two opcode bits, six address bits MSB first
  task automatic command(logic [1:0] op, logic [5:0] a, bit nz);
    wr(1'b0, 8'hE0);
    wr(1'b1, 8'hC0);            noise(nz);
    wr(1'b1, step(op[1]));      noise(nz);
    wr(1'b1, step(op[0]));      noise(nz);
    for (int i = 5; i >= 0; i--) begin
      wr(1'b1, step(a[i]));     noise(nz);
    end
  endtask

  task automatic read_words(logic [5:0] a, int n, bit nz, string tag);
    logic [7:0]  r;
    logic [15:0] w;
    bit          fmt_bad;
    command(2'b10, a, nz);
    rd(1'b1, r);
    check({tag, " R6 dummy read bit"}, r, 8'h00);
    for (int k = 0; k < n; k++) begin
      w = '0; fmt_bad = 1'b0;
      for (int b = 0; b < 16; b++) begin
        rd(1'b1, r);
        if ((r & 8'hEF) != 0) fmt_bad = 1'b1;
        w = {w[14:0], r[4]};
        noise(nz);
      end
      check({tag, " R7 read format"}, 32'(fmt_bad), 32'd0);
      check({tag, " R5 R8 word read"}, w, model[6'(a + 6'(k))]);
    end
  endtask

  task automatic write_words(logic [5:0] a, int n, bit nz);
    logic [15:0] v;
    command(2'b01, a, nz);
    wr(1'b1, step(1'($urandom)));   // R6 dummy write stores nothing
    for (int k = 0; k < n; k++) begin
      v = 16'($urandom);
      for (int b = 15; b >= 0; b--) begin
        wr(1'b1, step(v[b]));
        noise(nz);
      end
      model[6'(a + 6'(k))] = v;
    end
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd4242));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_wdata = 0;
    load_en = 0; load_addr = 0; load_word = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R11 rdata after reset", bus_rdata, 8'h00);
    rd(1'b0, r); check("R11 direction after reset", r, 8'h00);
    rd(1'b1, r); check("R10 R11 data read in ready", r, 8'h00);

    // R12 side-port preload
    for (int i = 0; i < 64; i++) begin
      model[i] = 16'($urandom);
      @(negedge clk);
      load_en = 1'b1; load_addr = 6'(i); load_word = model[i];
    end
    @(negedge clk); load_en = 1'b0;
    read_words(6'd5, 2, 1'b0, "R12 preload");

    // R13 read data holds
    rd(1'b0, r);
    repeat (5) @(negedge clk);
    check("R13 rdata holds", bus_rdata, r);

    // R2 direction field and R1 ignored control write
    wr(1'b0, 8'hD0); rd(1'b0, r); check("R2 direction readback", r, 8'h10);
    wr(1'b0, 8'h60); rd(1'b0, r); check("R1 ignored control write", r, 8'h10);
    wr(1'b0, 8'hF0); rd(1'b0, r); check("R2 direction 11", r, 8'h30);

    // R8 R9 write across the 63 to 0 boundary, then read back
    write_words(6'd63, 2, 1'b0);
    read_words(6'd63, 2, 1'b0, "R8 R9 wrap");

    // R4 opcodes 0 and 3 move no data
    for (int op = 0; op < 4; op += 3) begin
      bit any = 1'b0;
      command(2'(op), 6'd20, 1'b0);
      for (int b = 0; b < 20; b++) begin
        rd(1'b1, r); if (r != 0) any = 1'b1;
        wr(1'b1, step(1'($urandom)));
      end
      check("R4 idle opcode reads zero", 32'(any), 32'd0);
    end
    read_words(6'd20, 2, 1'b0, "R4 word unchanged");

    // R10 reading during the address steps disturbs nothing
    wr(1'b0, 8'hE0); wr(1'b1, 8'hC0); wr(1'b1, step(1)); wr(1'b1, step(0));
    wr(1'b1, step(0)); wr(1'b1, step(0));
    rd(1'b1, r); check("R10 read in address step", r, 8'h00);
    wr(1'b1, step(1)); wr(1'b1, step(0)); wr(1'b1, step(1)); wr(1'b1, step(1));
    rd(1'b1, r); check("R6 dummy after mid-command read", r, 8'h00);
    begin
      logic [15:0] w = '0;
      for (int b = 0; b < 16; b++) begin rd(1'b1, r); w = {w[14:0], r[4]}; end
      check("R10 R3 word 11 after mid read", w, model[11]);
    end

    // R1 R3 constrained random commands with interleaved ignored writes
    for (int it = 0; it < 40; it++) begin
      logic [5:0] a = 6'($urandom);
      int n = 1 + ($urandom % 2);
      if ($urandom % 2) write_words(a, n, 1'b1);
      read_words(a, n, 1'b1, "R1 R3 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule